// File: doc/BRIEF.md
# Byte Register Bank with 16-bit Pointer Pairs

This block is the working-register store of a small 8-bit processing datapath. It holds 32 byte-wide registers. Two operand ports read any two registers combinationally. One byte write port stores a result on the next rising clock edge, so an operation that reads two registers and writes one back can finish every cycle. A write-through path returns the value being written on any read port that addresses the same register in that cycle. An instruction that depends on the previous result therefore sees the fresh value with no stall.

The top six registers are also grouped into three 16-bit pointer pairs. Pair 0 is registers 26 and 27, pair 1 is 28 and 29, and pair 2 is 30 and 31. In each pair the lower-numbered register holds the low byte. The pointer read port returns the whole pair for indirect data addressing. The 16-bit pointer write port replaces both bytes in one cycle, which is what post-increment and pre-decrement address updates need. Pair 2 is also driven at all times onto a dedicated output that serves as the byte address for constant-table fetches from program memory. Both read ports and all write ports are plain per-cycle control signals with no handshake. Every cycle accepts a request, so there is no back-pressure to manage.

Top module: `gpr_bank`

## Requirements
- R1: A byte write (`wr_en`=1) stores `wr_data` into register `wr_idx` at the rising edge. Any of the 32 registers (index 0..31) then reads back that value from the next cycle on.
- R2: The two operand ports are independent. `opa_data` always shows the register chosen by `opa_idx`, and `opb_data` shows the one chosen by `opb_idx`, in the same cycle with no clock delay.
- R3: When a read port addresses the register that the byte write port is writing in the same cycle, the port shows the new `wr_data`, not the old contents.
- R4: `ptr_rd_sel` chooses a pair: 2'b00 selects registers 27:26, 2'b01 selects 29:28 and 2'b10 selects 31:30. `ptr_rd_data` is {higher register, lower register}.
- R5: A pointer write (`ptr_wr_en`=1 with `ptr_wr_sel` in 0..2) loads `ptr_wr_data[7:0]` into the lower register and `ptr_wr_data[15:8]` into the higher register of the pair at a single edge. In that same cycle, every read port that addresses either byte shows the new bytes.
- R6: If a byte write and a pointer write hit the same pair register in one cycle, the pointer byte is the one stored and the one shown.
- R7: Selector value 2'b11 is reserved. `ptr_rd_data` reads 16'h0000, and a pointer write with that selector changes no register.
- R8: `tbl_addr` always equals {register 31, register 30}, and it follows pending writes to those registers with the same write-through as the read ports.
- R9: A synchronous reset (`rst`=1 at a rising edge) clears all 32 registers to zero.
- R10: In a cycle with no byte write and no effective pointer write, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opa_idx | input | 5 | Register index for operand port A |
| opa_data | output | 8 | Operand A value, write-through |
| opb_idx | input | 5 | Register index for operand port B |
| opb_data | output | 8 | Operand B value, write-through |
| wr_en | input | 1 | Byte write enable |
| wr_idx | input | 5 | Byte write register index |
| wr_data | input | 8 | Byte write value |
| ptr_rd_sel | input | 2 | Pointer read pair select (11 reserved) |
| ptr_rd_data | output | 16 | Selected pair {high, low} |
| ptr_wr_en | input | 1 | Pointer write enable |
| ptr_wr_sel | input | 2 | Pointer write pair select (11 ignored) |
| ptr_wr_data | input | 16 | Pointer write value {high, low} |
| tbl_addr | output | 16 | Pair 2 value for program-memory table fetches |

## Verification
A corrupted register, or a write that lands in the wrong slot, shows up only when that register is next read. The bench therefore writes distinct patterns to every index and reads each one back in the very next cycle, so a stale or misplaced byte appears within one cycle of the faulty edge. Write-through faults, such as old data on a read that matches the write, or a wrong winner when a pointer write collides with a byte write, are visible in the same cycle as the write. They are checked before that edge. A swapped byte order or a wrong pair mapping appears at once on `ptr_rd_data` or `tbl_addr` when the pair is read against its individual bytes.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int GPR_COUNT     = 32;
  localparam int GPR_WIDTH     = 8;
  localparam int GPR_PAIR_BASE = 26;
  localparam int GPR_PAIRS     = 3;

  typedef enum logic [1:0] {
    PAIR_LOW_PTR  = 2'd0,
    PAIR_MID_PTR  = 2'd1,
    PAIR_TBL_PTR  = 2'd2,
    PAIR_RESERVED = 2'd3
  } pair_sel_e;
endpackage

// File: rtl/gpr_write_merge.sv
// Resolves this cycle's writes into the next-state image of the bank.
// The same image feeds the read ports, which gives write-through.
module gpr_write_merge #(
  parameter int N     = gpr_pkg::GPR_COUNT,
  parameter int W     = gpr_pkg::GPR_WIDTH,
  parameter int BASE  = gpr_pkg::GPR_PAIR_BASE,
  parameter int PAIRS = gpr_pkg::GPR_PAIRS,
  localparam int IW   = $clog2(N),
  localparam int PW   = 2 * W
) (
  input  logic [N-1:0][W-1:0] cur_q,
  input  logic                wr_en,
  input  logic [IW-1:0]       wr_idx,
  input  logic [W-1:0]        wr_data,
  input  logic                pwr_en,
  input  logic [1:0]          pwr_sel,
  input  logic [PW-1:0]       pwr_data,
  output logic [N-1:0][W-1:0] nxt_q
);
  logic          pair_ok;
  logic [IW-1:0] pair_lo;
  logic [IW-1:0] pair_hi;

  assign pair_ok = pwr_en && (int'(pwr_sel) < PAIRS);
  assign pair_lo = IW'(BASE + 2 * int'(pwr_sel));
  assign pair_hi = IW'(BASE + 2 * int'(pwr_sel) + 1);

  // The pointer update is applied last so that it wins over a byte write.
  always_comb begin
    nxt_q = cur_q;
    if (wr_en) begin
      nxt_q[wr_idx] = wr_data;
    end
    if (pair_ok) begin
      nxt_q[pair_lo] = pwr_data[W-1:0];
      nxt_q[pair_hi] = pwr_data[PW-1:W];
    end
  end
endmodule

// File: rtl/gpr_store.sv
// The bank flops; synchronous clear.
module gpr_store #(
  parameter int N = gpr_pkg::GPR_COUNT,
  parameter int W = gpr_pkg::GPR_WIDTH
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0][W-1:0] nxt_q,
  output logic [N-1:0][W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      q <= nxt_q;
    end
  end

  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (q == '0));
endmodule

// File: rtl/gpr_pair_port.sv
// Reads one 16-bit pointer pair; reserved selectors read as zero.
module gpr_pair_port #(
  parameter int N     = gpr_pkg::GPR_COUNT,
  parameter int W     = gpr_pkg::GPR_WIDTH,
  parameter int BASE  = gpr_pkg::GPR_PAIR_BASE,
  parameter int PAIRS = gpr_pkg::GPR_PAIRS,
  localparam int IW   = $clog2(N),
  localparam int PW   = 2 * W
) (
  input  logic [1:0]          sel,
  input  logic [N-1:0][W-1:0] regs,
  output logic [PW-1:0]       pair
);
  logic [IW-1:0] lo_idx;
  logic [IW-1:0] hi_idx;

  assign lo_idx = IW'(BASE + 2 * int'(sel));
  assign hi_idx = IW'(BASE + 2 * int'(sel) + 1);

  always_comb begin
    if (int'(sel) < PAIRS) begin
      pair = {regs[hi_idx], regs[lo_idx]};
    end else begin
      pair = '0;
    end
  end
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank #(
  parameter int N     = gpr_pkg::GPR_COUNT,
  parameter int W     = gpr_pkg::GPR_WIDTH,
  parameter int BASE  = gpr_pkg::GPR_PAIR_BASE,
  parameter int PAIRS = gpr_pkg::GPR_PAIRS,
  localparam int IW   = $clog2(N),
  localparam int PW   = 2 * W,
  localparam int NRD  = 2,
  localparam int TBLSEL = PAIRS - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] opa_idx,
  output logic [W-1:0]  opa_data,
  input  logic [IW-1:0] opb_idx,
  output logic [W-1:0]  opb_data,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [1:0]    ptr_rd_sel,
  output logic [PW-1:0] ptr_rd_data,
  input  logic          ptr_wr_en,
  input  logic [1:0]    ptr_wr_sel,
  input  logic [PW-1:0] ptr_wr_data,
  output logic [PW-1:0] tbl_addr
);
  logic [N-1:0][W-1:0]   q;
  logic [N-1:0][W-1:0]   nxt_q;
  logic [NRD-1:0][IW-1:0] rd_idx;
  logic [NRD-1:0][W-1:0]  rd_val;

  gpr_write_merge #(.N(N), .W(W), .BASE(BASE), .PAIRS(PAIRS)) merge_i (
    .cur_q    (q),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .pwr_en   (ptr_wr_en),
    .pwr_sel  (ptr_wr_sel),
    .pwr_data (ptr_wr_data),
    .nxt_q    (nxt_q)
  );

  gpr_store #(.N(N), .W(W)) store_i (
    .clk   (clk),
    .rst   (rst),
    .nxt_q (nxt_q),
    .q     (q)
  );

  assign rd_idx[0] = opa_idx;
  assign rd_idx[1] = opb_idx;

  for (genvar p = 0; p < NRD; p++) begin : g_oprd
    assign rd_val[p] = nxt_q[rd_idx[p]];
  end

  assign opa_data = rd_val[0];
  assign opb_data = rd_val[1];

  gpr_pair_port #(.N(N), .W(W), .BASE(BASE), .PAIRS(PAIRS)) ptr_rd_i (
    .sel  (ptr_rd_sel),
    .regs (nxt_q),
    .pair (ptr_rd_data)
  );

  gpr_pair_port #(.N(N), .W(W), .BASE(BASE), .PAIRS(PAIRS)) tbl_rd_i (
    .sel  (2'(TBLSEL)),
    .regs (nxt_q),
    .pair (tbl_addr)
  );

  // ---------------- checks ----------------
  logic [IW-1:0] pwr_lo_idx;
  logic [IW-1:0] pwr_hi_idx;
  logic [IW-1:0] tbl_lo_idx;
  logic [IW-1:0] tbl_hi_idx;
  logic          pwr_valid;
  assign pwr_lo_idx = IW'(BASE + 2 * int'(ptr_wr_sel));
  assign pwr_hi_idx = IW'(BASE + 2 * int'(ptr_wr_sel) + 1);
  assign tbl_lo_idx = IW'(BASE + 2 * TBLSEL);
  assign tbl_hi_idx = IW'(BASE + 2 * TBLSEL + 1);
  assign pwr_valid  = ptr_wr_en && (int'(ptr_wr_sel) < PAIRS);

  // R1
  byte_land_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ptr_wr_en) |=> (q[$past(wr_idx)] == $past(wr_data)));

  // R3
  bypass_a_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ptr_wr_en && opa_idx == wr_idx) |-> (opa_data == wr_data));

  // R3
  bypass_b_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ptr_wr_en && opb_idx == wr_idx) |-> (opb_data == wr_data));

  // R5
  pair_land_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_valid |=> ({q[$past(pwr_hi_idx)], q[$past(pwr_lo_idx)]} == $past(ptr_wr_data)));

  // R7
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ptr_rd_sel == 2'b11) |-> (ptr_rd_data == '0));

  // R7
  rsvd_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (ptr_wr_en && ptr_wr_sel == 2'b11 && !wr_en) |=> $stable(q));

  // R8
  tbl_track_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !ptr_wr_en) |-> (tbl_addr == {q[tbl_hi_idx], q[tbl_lo_idx]}));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !ptr_wr_en) |=> $stable(q));
endmodule

// File: tb/gpr_bank_tb.sv
`timescale 1ns/1ps
module gpr_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  opa_idx, opb_idx, wr_idx;
  logic [7:0]  opa_data, opb_data, wr_data;
  logic        wr_en, ptr_wr_en;
  logic [1:0]  ptr_rd_sel, ptr_wr_sel;
  logic [15:0] ptr_rd_data, ptr_wr_data, tbl_addr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  gpr_bank dut_i (
    .clk(clk), .rst(rst),
    .opa_idx(opa_idx), .opa_data(opa_data),
    .opb_idx(opb_idx), .opb_data(opb_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .ptr_rd_sel(ptr_rd_sel), .ptr_rd_data(ptr_rd_data),
    .ptr_wr_en(ptr_wr_en), .ptr_wr_sel(ptr_wr_sel), .ptr_wr_data(ptr_wr_data),
    .tbl_addr(tbl_addr)
  );

  typedef struct packed {
    logic        we;
    logic [4:0]  wi;
    logic [7:0]  wd;
    logic        pe;
    logic [1:0]  ps;
    logic [15:0] pd;
    logic [4:0]  ra;
    logic [4:0]  rb;
    logic [1:0]  prs;
    logic [7:0]  ea;
    logic [7:0]  eb;
    logic [15:0] ep;
    logic [15:0] ez;
  } vec_t;

  // One row per cycle: stimulus, then values expected before the edge.
  localparam vec_t VEC [10] = '{
    '{1'b1, 5'd5,  8'h3C, 1'b0, 2'd0, 16'h0000, 5'd5,  5'd6,  2'd0, 8'h3C, 8'h00, 16'h0000, 16'h0000},
    '{1'b1, 5'd6,  8'hA5, 1'b0, 2'd0, 16'h0000, 5'd5,  5'd6,  2'd0, 8'h3C, 8'hA5, 16'h0000, 16'h0000},
    '{1'b1, 5'd26, 8'h11, 1'b0, 2'd0, 16'h0000, 5'd26, 5'd0,  2'd0, 8'h11, 8'h00, 16'h0011, 16'h0000},
    '{1'b1, 5'd27, 8'h22, 1'b0, 2'd0, 16'h0000, 5'd27, 5'd26, 2'd0, 8'h22, 8'h11, 16'h2211, 16'h0000},
    '{1'b1, 5'd28, 8'h55, 1'b1, 2'd1, 16'hBEEF, 5'd28, 5'd29, 2'd1, 8'hEF, 8'hBE, 16'hBEEF, 16'h0000},
    '{1'b0, 5'd0,  8'h00, 1'b1, 2'd2, 16'h1234, 5'd30, 5'd31, 2'd2, 8'h34, 8'h12, 16'h1234, 16'h1234},
    '{1'b0, 5'd0,  8'h00, 1'b1, 2'd3, 16'hFFFF, 5'd26, 5'd31, 2'd3, 8'h11, 8'h12, 16'h0000, 16'h1234},
    '{1'b0, 5'd0,  8'h00, 1'b0, 2'd0, 16'h0000, 5'd5,  5'd29, 2'd0, 8'h3C, 8'hBE, 16'h2211, 16'h1234},
    '{1'b1, 5'd30, 8'h99, 1'b0, 2'd0, 16'h0000, 5'd30, 5'd28, 2'd2, 8'h99, 8'hEF, 16'h1299, 16'h1299},
    '{1'b1, 5'd0,  8'h77, 1'b1, 2'd0, 16'h2212, 5'd0,  5'd27, 2'd0, 8'h77, 8'h22, 16'h2212, 16'h1299}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    ptr_wr_en = 1'b0; ptr_wr_sel = '0; ptr_wr_data = '0;
    opa_idx = '0; opb_idx = '0; ptr_rd_sel = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R9: every register reads zero after reset
    for (int i = 0; i < 32; i++) begin
      opa_idx = 5'(i);
      opb_idx = 5'(31 - i);
      #1;
      check("R9 opa", {8'h00, opa_data}, 16'h0000);
      check("R9 opb", {8'h00, opb_data}, 16'h0000);
    end
    check("R9 tbl", tbl_addr, 16'h0000);

    // R1 R2 R3 R4 R5 R6 R7 R8 R10: vector table
    for (int v = 0; v < 10; v++) begin
      @(negedge clk);
      wr_en = VEC[v].we; wr_idx = VEC[v].wi; wr_data = VEC[v].wd;
      ptr_wr_en = VEC[v].pe; ptr_wr_sel = VEC[v].ps; ptr_wr_data = VEC[v].pd;
      opa_idx = VEC[v].ra; opb_idx = VEC[v].rb; ptr_rd_sel = VEC[v].prs;
      #1;
      check("R2/R3/R6 opa", {8'h00, opa_data}, {8'h00, VEC[v].ea});
      check("R2/R3/R6 opb", {8'h00, opb_data}, {8'h00, VEC[v].eb});
      check("R4/R5/R7 ptr", ptr_rd_data, VEC[v].ep);
      check("R8 tbl", tbl_addr, VEC[v].ez);
    end

    // R1: each index written, then read back on the next cycle with no write
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      idle();
      wr_en = 1'b1; wr_idx = 5'(i); wr_data = 8'(i) ^ 8'h5A;
      @(negedge clk);
      idle();
      opa_idx = 5'(i);
      opb_idx = 5'(i);
      #1;
      check("R1 opa", {8'h00, opa_data}, {8'h00, 8'(i) ^ 8'h5A});
      check("R1 opb", {8'h00, opb_data}, {8'h00, 8'(i) ^ 8'h5A});
    end

    // R4 r8_: pair views of the last pattern, low byte in the lower index
    @(negedge clk);
    ptr_rd_sel = 2'd1;
    #1;
    check("R4 pair1", ptr_rd_data, {8'd29 ^ 8'h5A, 8'd28 ^ 8'h5A});
    check("R8 tbl idle", tbl_addr, {8'd31 ^ 8'h5A, 8'd30 ^ 8'h5A});

    // R6: pointer write high byte collides with byte write to register 31
    @(negedge clk);
    idle();
    wr_en = 1'b1; wr_idx = 5'd31; wr_data = 8'hC3;
    ptr_wr_en = 1'b1; ptr_wr_sel = 2'd2; ptr_wr_data = 16'h8001;
    @(negedge clk);
    idle();
    opa_idx = 5'd31;
    #1;
    check("R6 stored", {8'h00, opa_data}, 16'h0080);

    // R10: idle cycles leave contents untouched
    repeat (3) @(negedge clk);
    opa_idx = 5'd7;
    #1;
    check("R10 hold", {8'h00, opa_data}, {8'h00, 8'd7 ^ 8'h5A});

    // R9: reset again wipes data
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    opa_idx = 5'd7; opb_idx = 5'd27;
    #1;
    check("R9 reclear a", {8'h00, opa_data}, 16'h0000);
    check("R9 reclear b", {8'h00, opb_data}, 16'h0000);
    check("R9 reclear tbl", tbl_addr, 16'h0000);

    finish_run();
  end
endmodule